// File: doc/BRIEF.md
# Parallel Memory Programming Controller

This block is the target-side sequencer for a pin-strobed parallel programming mode. It sits between an 8-bit programming data bus and two memory arrays: a program flash of 16-bit words and a byte-wide data EEPROM. A 2-bit action code on `actSel`, qualified by `byteSel`, chooses what the next rising edge of `loadStrobe` captures from the bus: a command, the high or low address byte, or the high or low data byte. Every latch keeps its value until it is reloaded.

A falling edge on `wrN` starts the operation named by the latched command. A write issues a one-cycle write enable to the selected array and holds `readyBusy` low for a fixed number of cycles. A chip erase emits a single erase pulse and leaves `readyBusy` high. Under a read command, pulling `oeN` low drives the selected byte onto `dataOut` and raises `dataOe`. All pins are sampled in the `clk` domain. The caller synchronises them beforehand.

Top module: `par_prog_ctrl`

## Requirements
- R1: After reset, `readyBusy` is 1, `dataOe` is 0 even with `oeN` low, and `flashWe`, `eepromWe` and `chipErase` are 0.
- R2: With `actSel`=2'b10, a `loadStrobe` rising edge latches `dataIn` as the command. Codes: 8'h10 write flash, 8'h11 write EEPROM, 8'h02 read flash, 8'h03 read EEPROM, 8'h80 chip erase.
- R3: With `actSel`=2'b00, a strobe edge latches the address byte: high if `byteSel`=1, low if 0. Only bit 0 of the high byte is kept, so `memAddr` = {hi[0], lo} spans 512 words.
- R4: With `actSel`=2'b01, a strobe edge latches a data byte: high if `byteSel`=1, low if 0. `memWrData` is {high, low}.
- R5: A strobe edge with `actSel`=2'b11 changes no latch.
- R6: A `wrN` falling edge under command 8'h10 gives one `flashWe` pulse. Under 8'h11 it gives one `eepromWe` pulse, and the EEPROM takes `memWrData[7:0]` at `memAddr[5:0]`.
- R7: After a write starts, `readyBusy` is low for exactly BUSY_CYCLES (default 8) clock cycles and then returns high.
- R8: A `wrN` falling edge while `readyBusy` is low is ignored. It causes no further write and does not extend the busy period.
- R9: Under command 8'h02 with `oeN` low, `dataOe` is 1 and `dataOut` is the flash word's low byte when `byteSel`=0 and its high byte when `byteSel`=1. With `oeN` high, or under a write command, `dataOe` is 0.
- R10: Under command 8'h03 with `oeN` low, `dataOut` is the EEPROM byte at `memAddr[5:0]`.
- R11: A `wrN` falling edge under command 8'h80 gives one `chipErase` pulse and leaves `readyBusy` high.
- R12: The address and command latches persist, so a later word can be written by reloading only the low address byte.
- R13: A strobe held high loads once, on its rising edge. Bus changes while it stays high are not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dataIn | input | 8 | Programming bus, inbound |
| dataOut | output | 8 | Programming bus, outbound read byte |
| dataOe | output | 1 | Bus drive enable for dataOut |
| actSel | input | 2 | Action code for the next load |
| byteSel | input | 1 | High/low byte select |
| loadStrobe | input | 1 | Load strobe, active on rising edge |
| wrN | input | 1 | Write/start, active on falling edge |
| oeN | input | 1 | Output enable, active low |
| readyBusy | output | 1 | 1 = ready, 0 = programming |
| memAddr | output | 9 | Word address to the arrays |
| memWrData | output | 16 | Write word (EEPROM uses low byte) |
| flashWe | output | 1 | Flash write pulse |
| eepromWe | output | 1 | EEPROM write pulse |
| chipErase | output | 1 | Erase pulse |
| memRdFlash | input | 16 | Flash word at memAddr |
| memRdEe | input | 8 | EEPROM byte at memAddr[5:0] |

## Verification
The bench targets several corner cases:
- A strobe held high while the bus changes. A level-sensitive latch would capture the last value instead of the first.
- An action code of 11 carrying new data. A loose decode would overwrite an address or data latch.
- A second write pulse inside the busy window. A controller that re-arms would write twice or stretch the busy period.
- Chip erase. A design that treats it as a write would drop `readyBusy`.
- A high address byte with spare bits set. This must not alias beyond 512 words.
- An upper/lower byte swap on readout, which shows up as swapped bytes.

// File: rtl/pprog_pkg.sv
package pprog_pkg;

  typedef enum logic [1:0] {
    ACT_ADDR = 2'b00,
    ACT_DATA = 2'b01,
    ACT_CMD  = 2'b10,
    ACT_NONE = 2'b11
  } act_e;

  localparam logic [7:0] CMD_WR_FLASH = 8'h10;
  localparam logic [7:0] CMD_WR_EE    = 8'h11;
  localparam logic [7:0] CMD_RD_FLASH = 8'h02;
  localparam logic [7:0] CMD_RD_EE    = 8'h03;
  localparam logic [7:0] CMD_ERASE    = 8'h80;

  typedef struct packed {
    logic ldCmd;
    logic ldAddrHi;
    logic ldAddrLo;
    logic ldDataHi;
    logic ldDataLo;
  } latch_stb_t;

endpackage

// File: rtl/pprog_ctrl.sv
module pprog_ctrl
  import pprog_pkg::*;
#(
  parameter int BUSY_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] actSel,
  input  logic       byteSel,
  input  logic       loadStrobe,
  input  logic       wrN,
  input  logic [7:0] cmdCode,
  output latch_stb_t stb,
  output logic       flashWe,
  output logic       eepromWe,
  output logic       eraseStb,
  output logic       readyBusy
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic          strobePrev;
  logic          wrPrev;
  logic [CW-1:0] busyCnt;
  logic          loadRise;
  logic          wrFall;
  logic          startReq;
  logic          isWrite;

  assign loadRise  = loadStrobe & ~strobePrev;
  assign wrFall    = ~wrN & wrPrev;
  assign readyBusy = (busyCnt == '0);
  assign startReq  = wrFall & readyBusy;
  assign isWrite   = (cmdCode == CMD_WR_FLASH) || (cmdCode == CMD_WR_EE);

  always_comb begin
    stb = '0;
    if (loadRise) begin
      case (actSel)
        ACT_CMD:  stb.ldCmd = 1'b1;
        ACT_ADDR: begin
          stb.ldAddrHi = byteSel;
          stb.ldAddrLo = ~byteSel;
        end
        ACT_DATA: begin
          stb.ldDataHi = byteSel;
          stb.ldDataLo = ~byteSel;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobePrev <= 1'b0;
      wrPrev     <= 1'b1;
      busyCnt    <= '0;
      flashWe    <= 1'b0;
      eepromWe   <= 1'b0;
      eraseStb   <= 1'b0;
    end else begin
      strobePrev <= loadStrobe;
      wrPrev     <= wrN;
      flashWe    <= startReq && (cmdCode == CMD_WR_FLASH);
      eepromWe   <= startReq && (cmdCode == CMD_WR_EE);
      eraseStb   <= startReq && (cmdCode == CMD_ERASE);
      if (startReq && isWrite)
        busyCnt <= CW'(BUSY_CYCLES);
      else if (busyCnt != '0)
        busyCnt <= busyCnt - 1'b1;
    end
  end

  p_one_action_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flashWe, eepromWe, eraseStb}));

  p_we_inside_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flashWe || eepromWe) |-> !readyBusy);

  p_busy_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busyCnt <= CW'(BUSY_CYCLES));

  p_no_write_while_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !readyBusy |=> !(flashWe || eepromWe));

  p_erase_keeps_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    eraseStb |-> (readyBusy && $past(readyBusy)));

endmodule

// File: rtl/pprog_dpath.sv
module pprog_dpath
  import pprog_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  latch_stb_t        stb,
  input  logic [7:0]        dataIn,
  input  logic              byteSel,
  input  logic              oeN,
  input  logic [15:0]       memRdFlash,
  input  logic [7:0]        memRdEe,
  output logic [7:0]        cmdCode,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memWrData,
  output logic [7:0]        dataOut,
  output logic              dataOe
);
  localparam int HI_W = ADDR_W - 8;

  logic [7:0]      cmdReg;
  logic [HI_W-1:0] addrHi;
  logic [7:0]      addrLo;
  logic [7:0]      dataHi;
  logic [7:0]      dataLo;
  logic            rdFlash;
  logic            rdEe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdReg <= '0;
      addrHi <= '0;
      addrLo <= '0;
      dataHi <= '0;
      dataLo <= '0;
    end else begin
      if (stb.ldCmd)    cmdReg <= dataIn;
      if (stb.ldAddrHi) addrHi <= dataIn[HI_W-1:0];
      if (stb.ldAddrLo) addrLo <= dataIn;
      if (stb.ldDataHi) dataHi <= dataIn;
      if (stb.ldDataLo) dataLo <= dataIn;
    end
  end

  assign cmdCode   = cmdReg;
  assign memAddr   = {addrHi, addrLo};
  assign memWrData = {dataHi, dataLo};
  assign rdFlash   = (cmdReg == CMD_RD_FLASH);
  assign rdEe      = (cmdReg == CMD_RD_EE);
  assign dataOe    = ~oeN & (rdFlash | rdEe);

  always_comb begin
    if (!dataOe)      dataOut = 8'h00;
    else if (rdEe)    dataOut = memRdEe;
    else if (byteSel) dataOut = memRdFlash[15:8];
    else              dataOut = memRdFlash[7:0];
  end

  p_single_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb));

  p_hold_addr_lo_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.ldAddrLo |=> $stable(addrLo));

  p_hold_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.ldCmd |=> $stable(cmdReg));

endmodule

// File: rtl/par_prog_ctrl.sv
module par_prog_ctrl
  import pprog_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int BUSY_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  output logic              dataOe,
  input  logic [1:0]        actSel,
  input  logic              byteSel,
  input  logic              loadStrobe,
  input  logic              wrN,
  input  logic              oeN,
  output logic              readyBusy,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memWrData,
  output logic              flashWe,
  output logic              eepromWe,
  output logic              chipErase,
  input  logic [15:0]       memRdFlash,
  input  logic [7:0]        memRdEe
);
  latch_stb_t stb;
  logic [7:0] cmdCode;

  pprog_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .actSel(actSel), .byteSel(byteSel),
    .loadStrobe(loadStrobe), .wrN(wrN), .cmdCode(cmdCode), .stb(stb),
    .flashWe(flashWe), .eepromWe(eepromWe), .eraseStb(chipErase),
    .readyBusy(readyBusy)
  );

  pprog_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .stb(stb), .dataIn(dataIn), .byteSel(byteSel),
    .oeN(oeN), .memRdFlash(memRdFlash), .memRdEe(memRdEe), .cmdCode(cmdCode),
    .memAddr(memAddr), .memWrData(memWrData), .dataOut(dataOut), .dataOe(dataOe)
  );

endmodule

// File: tb/par_prog_ctrl_bench.sv
module par_prog_ctrl_bench;
  localparam int BUSY = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  dataIn = 8'h00;
  logic [7:0]  dataOut;
  logic        dataOe;
  logic [1:0]  actSel = 2'b11;
  logic        byteSel = 1'b0;
  logic        loadStrobe = 1'b0;
  logic        wrN = 1'b1;
  logic        oeN = 1'b1;
  logic        readyBusy;
  logic [8:0]  memAddr;
  logic [15:0] memWrData;
  logic        flashWe, eepromWe, chipErase;
  logic [15:0] memRdFlash;
  logic [7:0]  memRdEe;

  logic [15:0] flashMem [512];
  logic [7:0]  eeMem [64];
  int flashWeCnt = 0, eeWeCnt = 0, eraseCnt = 0, lowCnt = 0;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  par_prog_ctrl #(.BUSY_CYCLES(BUSY)) u_par_prog_ctrl (
    .clk(clk), .rst_n(rst_n), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .actSel(actSel), .byteSel(byteSel), .loadStrobe(loadStrobe), .wrN(wrN),
    .oeN(oeN), .readyBusy(readyBusy), .memAddr(memAddr), .memWrData(memWrData),
    .flashWe(flashWe), .eepromWe(eepromWe), .chipErase(chipErase),
    .memRdFlash(memRdFlash), .memRdEe(memRdEe)
  );

  assign memRdFlash = flashMem[memAddr];
  assign memRdEe    = eeMem[memAddr[5:0]];

  always @(posedge clk) begin
    if (flashWe)   begin flashMem[memAddr] <= memWrData; flashWeCnt <= flashWeCnt + 1; end
    if (eepromWe)  begin eeMem[memAddr[5:0]] <= memWrData[7:0]; eeWeCnt <= eeWeCnt + 1; end
    if (chipErase) eraseCnt <= eraseCnt + 1;
  end

  always @(negedge clk) if (rst_n && !readyBusy) lowCnt <= lowCnt + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic loadItem(input logic [1:0] act, input logic bs, input logic [7:0] val);
    @(negedge clk); actSel = act; byteSel = bs; dataIn = val; loadStrobe = 1'b1;
    @(negedge clk); loadStrobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic doWrite();
    @(negedge clk); wrN = 1'b0;
    @(negedge clk); wrN = 1'b1;
    for (int i = 0; i < 100 && !readyBusy; i++) @(negedge clk);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    oeN = 1'b0;
    @(negedge clk);
    check(readyBusy === 1'b1, "R1 ready", readyBusy, 1);
    check(dataOe === 1'b0, "R1 dataOe", dataOe, 0);
    check({flashWe, eepromWe, chipErase} === 3'b000, "R1 strobes", {flashWe, eepromWe, chipErase}, 0);
    oeN = 1'b1;
  endtask

  task automatic t_flash_write();
    int l0, w0;
    loadItem(2'b10, 1'b0, 8'h10);
    loadItem(2'b00, 1'b1, 8'h03);
    loadItem(2'b00, 1'b0, 8'hA5);
    loadItem(2'b01, 1'b0, 8'h3C);
    loadItem(2'b01, 1'b1, 8'h9E);
    l0 = lowCnt; w0 = flashWeCnt;
    doWrite();
    check(flashMem[9'h1A5] === 16'h9E3C, "R3 R4 R6 word at 0x1A5", flashMem[9'h1A5], 16'h9E3C);
    check(flashWeCnt - w0 == 1, "R2 R6 flash pulse count", flashWeCnt - w0, 1);
    check(lowCnt - l0 == BUSY, "R7 busy length", lowCnt - l0, BUSY);
    check(readyBusy === 1'b1, "R7 ready again", readyBusy, 1);
  endtask

  task automatic t_next_word();
    loadItem(2'b00, 1'b0, 8'hA6);
    loadItem(2'b01, 1'b0, 8'h55);
    doWrite();
    check(flashMem[9'h1A6] === 16'h9E55, "R12 reuse latches", flashMem[9'h1A6], 16'h9E55);
  endtask

  task automatic t_no_action();
    int w0;
    loadItem(2'b00, 1'b0, 8'hA7);
    loadItem(2'b11, 1'b0, 8'h00);
    loadItem(2'b11, 1'b1, 8'h00);
    w0 = flashWeCnt;
    doWrite();
    check(flashMem[9'h1A7] === 16'h9E55, "R5 code 11 ignored", flashMem[9'h1A7], 16'h9E55);
    check(flashWeCnt - w0 == 1, "R5 command kept", flashWeCnt - w0, 1);
  endtask

  task automatic t_level_strobe();
    loadItem(2'b00, 1'b0, 8'hA8);
    @(negedge clk); actSel = 2'b01; byteSel = 1'b0; dataIn = 8'h11; loadStrobe = 1'b1;
    @(negedge clk); dataIn = 8'h22;
    @(negedge clk); dataIn = 8'h33;
    @(negedge clk); loadStrobe = 1'b0;
    @(negedge clk);
    doWrite();
    check(flashMem[9'h1A8] === 16'h9E11, "R13 edge load only", flashMem[9'h1A8], 16'h9E11);
  endtask

  task automatic t_busy_ignore();
    int l0, w0;
    loadItem(2'b00, 1'b0, 8'hA9);
    l0 = lowCnt; w0 = flashWeCnt;
    @(negedge clk); wrN = 1'b0;
    @(negedge clk); wrN = 1'b1;
    @(negedge clk); wrN = 1'b0;
    @(negedge clk); wrN = 1'b1;
    for (int i = 0; i < 100 && !readyBusy; i++) @(negedge clk);
    @(negedge clk); @(negedge clk);
    check(flashWeCnt - w0 == 1, "R8 single write", flashWeCnt - w0, 1);
    check(lowCnt - l0 == BUSY, "R8 busy not extended", lowCnt - l0, BUSY);
  endtask

  task automatic t_eeprom();
    int l0, w0, e0;
    loadItem(2'b10, 1'b0, 8'h11);
    loadItem(2'b00, 1'b0, 8'h47);
    loadItem(2'b01, 1'b0, 8'hC3);
    l0 = lowCnt; w0 = flashWeCnt; e0 = eeWeCnt;
    oeN = 1'b0;
    @(negedge clk);
    check(dataOe === 1'b0, "R9 no drive under write cmd", dataOe, 0);
    oeN = 1'b1;
    doWrite();
    check(eeMem[7] === 8'hC3, "R6 eeprom byte", eeMem[7], 8'hC3);
    check(eeWeCnt - e0 == 1 && flashWeCnt == w0, "R6 eeprom pulse only", eeWeCnt - e0, 1);
    check(lowCnt - l0 == BUSY, "R7 eeprom busy", lowCnt - l0, BUSY);
    loadItem(2'b10, 1'b0, 8'h03);
    @(negedge clk); oeN = 1'b0;
    @(negedge clk);
    check(dataOe === 1'b1, "R10 drive", dataOe, 1);
    check(dataOut === 8'hC3, "R10 eeprom read", dataOut, 8'hC3);
    oeN = 1'b1;
  endtask

  task automatic t_read_flash();
    loadItem(2'b10, 1'b0, 8'h02);
    loadItem(2'b00, 1'b1, 8'h01);
    loadItem(2'b00, 1'b0, 8'hA5);
    @(negedge clk); oeN = 1'b0; byteSel = 1'b0;
    @(negedge clk);
    check(dataOe === 1'b1, "R9 drive", dataOe, 1);
    check(dataOut === 8'h3C, "R9 low byte", dataOut, 8'h3C);
    byteSel = 1'b1;
    @(negedge clk);
    check(dataOut === 8'h9E, "R9 high byte", dataOut, 8'h9E);
    oeN = 1'b1;
    @(negedge clk);
    check(dataOe === 1'b0, "R9 release", dataOe, 0);
  endtask

  task automatic t_erase();
    int l0, w0, x0;
    loadItem(2'b10, 1'b0, 8'h80);
    l0 = lowCnt; w0 = flashWeCnt; x0 = eraseCnt;
    doWrite();
    check(eraseCnt - x0 == 1, "R11 erase pulse", eraseCnt - x0, 1);
    check(lowCnt == l0, "R11 ready unchanged", lowCnt - l0, 0);
    check(flashWeCnt == w0, "R11 no flash write", flashWeCnt - w0, 0);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) flashMem[i] = 16'h0000;
    for (int i = 0; i < 64; i++) eeMem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_flash_write();
    t_next_word();
    t_no_action();
    t_level_strobe();
    t_busy_ignore();
    t_eeprom();
    t_read_flash();
    t_erase();
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule